// File: doc/BRIEF.md
# NOR Flash Word-Program Sequencer

This block sits between a simple host request port and an asynchronous parallel NOR flash. A host request is either a read or a program.

A read becomes one read cycle on the flash bus. The returned word comes back with a one-clock valid pulse.

A program request expands into four bus write cycles: two unlock writes, a program-setup write, and the write that carries the target address and data. The block then watches the device's ready/busy line until the device's internal algorithm finishes. The device is back in read mode after that, so no exit command is sent.

While a program operation is in flight, `host_busy` is high and new requests are not acknowledged. If the device never reports ready, a wait counter ends the operation after a set number of clocks and raises `host_err`.

All flash strobes come straight from flops. The data-bus output enable is never active together with a low output enable.

Top module: `nor_pgm_seq`

## Requirements
- R1: During and after reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `fl_dq_oe` is low, and `host_busy`, `host_err` and `rd_valid` are low.
- R2: A request with `host_wr`=0 that is acknowledged while idle produces exactly RD_CLKS clocks with `fl_ce_n`=0, `fl_oe_n`=0, `fl_we_n`=1 and `fl_addr` equal to the requested address.
- R3: One clock after the last read clock, `rd_valid` is high for one clock and `rd_data` holds the word the flash drove during the read cycle.
- R4: A request with `host_wr`=1 produces four bus writes in this order: address 0x555 with data 0xAA, address 0x2AA with data 0x55, address 0x555 with data 0xA0, then the host address with the host data.
- R5: In every write cycle, `fl_we_n` is low for exactly WE_LOW_CLKS clocks. Address and data on the bus are unchanged for one clock before `fl_we_n` falls and for one clock after it rises, and the bus is driven during that time.
- R6: `host_busy` is high from the clock after a program request is acknowledged until completion. `fl_rdy` (1 = ready) passes through SYNC_STAGES flops and is ignored for the first SYNC_STAGES+1 wait clocks. Busy clears on the clock after the synchronized ready is seen.
- R7: Once the data write is complete, no further bus writes occur. A following read of the programmed address returns the programmed data.
- R8: `host_ack` is never high while `host_busy` is high. A request held during a program operation is acknowledged only once the block is idle again.
- R9: If ready is not seen within TMO_LIMIT wait clocks, `host_busy` falls at the end of the TMO_LIMIT-th wait clock and `host_err` rises at the same moment. `host_err` then stays high.
- R10: `host_err` clears on the clock edge where the next request is acknowledged.
- R11: `fl_dq_oe` is never high while `fl_oe_n` is low. `fl_oe_n` stays high whenever `fl_we_n` is low, and `fl_we_n` is only low with `fl_ce_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request pending, held until acknowledged |
| host_wr | input | 1 | 1 = program word, 0 = read word |
| host_addr | input | AW | Word address |
| host_wdata | input | DW | Word to program |
| host_ack | output | 1 | Request taken on this clock edge |
| host_busy | output | 1 | Program operation in flight |
| host_err | output | 1 | Last program operation timed out |
| rd_valid | output | 1 | One-clock pulse, read word available |
| rd_data | output | DW | Read word |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash word address |
| fl_dq_o | output | DW | Data toward the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_o` |
| fl_dq_i | input | DW | Data from the flash |
| fl_rdy | input | 1 | Flash ready/busy, 1 = ready |

## Verification
The assertions assume three things about the inputs:
- The host keeps `host_req` and its fields steady until `host_ack`.
- The flash pulls `fl_rdy` low soon enough after the data write that the blanking window covers the synchronizer delay.
- `fl_dq_i` is only meaningful while both enables are low.

The bench's flash model stays within these limits. It lowers ready on the first falling clock edge after `fl_we_n` rises on a complete command sequence. Its programmed busy length is always two clocks or more. Every host request is held until it is acknowledged.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSU,
    ST_WLO,
    ST_WHD,
    ST_WAIT
  } nps_state_e;

  localparam int CMD_STEPS = 4;

  localparam logic [11:0] SEQ_A0 = 12'h555;
  localparam logic [11:0] SEQ_A1 = 12'h2AA;
  localparam logic [11:0] SEQ_A2 = 12'h555;
  localparam logic [7:0]  SEQ_D0 = 8'hAA;
  localparam logic [7:0]  SEQ_D1 = 8'h55;
  localparam logic [7:0]  SEQ_D2 = 8'hA0;

endpackage

// File: rtl/nps_sync.sv
module nps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[i-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/nps_wait_timer.sv
module nps_wait_timer #(
  parameter int LIMIT = 4096,
  parameter int BLANK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rdy,
  output logic fin_ok,
  output logic fin_tmo
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_lim;

  assign at_lim  = (cnt_q == TW'(LIMIT - 1));
  assign fin_ok  = run && rdy && (cnt_q >= TW'(BLANK));
  assign fin_tmo = run && !fin_ok && at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!at_lim) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMO_LEAVES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_tmo |=> !run); // R9

endmodule

// File: rtl/nor_pgm_seq.sv
module nor_pgm_seq
  import nps_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int WE_LOW_CLKS = 2,
  parameter int RD_CLKS     = 2,
  parameter int TMO_LIMIT   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic          host_busy,
  output logic          host_err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  input  logic          fl_rdy
);

  localparam int         PH_MAX    = (WE_LOW_CLKS > RD_CLKS) ? WE_LOW_CLKS : RD_CLKS;
  localparam int         CW        = $clog2(PH_MAX + 1);
  localparam int         BLANK     = SYNC_STAGES + 1;
  localparam logic [1:0] LAST_STEP = 2'(CMD_STEPS - 1);

  nps_state_e    state_q, state_d;
  logic [1:0]    step_q, step_d;
  logic [CW-1:0] ph_q, ph_d;
  logic [AW-1:0] tgt_a_q;
  logic [DW-1:0] tgt_d_q;
  logic [AW-1:0] cmd_a;
  logic [DW-1:0] cmd_d;
  logic          cap_rd;
  logic          ce_d, oe_d, we_d, drv_d;
  logic          rdy_s, fin_ok, fin_tmo, waiting;

  assign host_ack  = (state_q == ST_IDLE) && host_req;
  assign host_busy = (state_q == ST_WSU) || (state_q == ST_WLO) ||
                     (state_q == ST_WHD) || (state_q == ST_WAIT);
  assign waiting   = (state_q == ST_WAIT);

  nps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(fl_rdy), .q(rdy_s)
  );

  nps_wait_timer #(.LIMIT(TMO_LIMIT), .BLANK(BLANK)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(waiting), .rdy(rdy_s),
    .fin_ok(fin_ok), .fin_tmo(fin_tmo)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ph_d    = ph_q;
    cap_rd  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (host_req) begin
        ph_d    = '0;
        step_d  = '0;
        state_d = host_wr ? ST_WSU : ST_RD;
      end
      ST_RD: if (ph_q == CW'(RD_CLKS - 1)) begin
        state_d = ST_IDLE;
        cap_rd  = 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
      ST_WSU: begin
        state_d = ST_WLO;
        ph_d    = '0;
      end
      ST_WLO: if (ph_q == CW'(WE_LOW_CLKS - 1)) state_d = ST_WHD;
              else ph_d = ph_q + 1'b1;
      ST_WHD: if (step_q == LAST_STEP) begin
        state_d = ST_WAIT;
      end else begin
        step_d  = step_q + 1'b1;
        state_d = ST_WSU;
      end
      ST_WAIT: if (fin_ok || fin_tmo) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobe decode of the next state, registered below
  always_comb begin
    ce_d  = 1'b0;
    oe_d  = 1'b0;
    we_d  = 1'b0;
    drv_d = 1'b0;
    unique case (state_d)
      ST_RD:         begin ce_d = 1'b1; oe_d = 1'b1; end
      ST_WSU, ST_WHD: begin ce_d = 1'b1; drv_d = 1'b1; end
      ST_WLO:        begin ce_d = 1'b1; we_d = 1'b1; drv_d = 1'b1; end
      default:       ;
    endcase
  end

  // command word selection
  always_comb begin
    case (step_q)
      2'd0:    begin cmd_a = AW'(SEQ_A0); cmd_d = DW'(SEQ_D0); end
      2'd1:    begin cmd_a = AW'(SEQ_A1); cmd_d = DW'(SEQ_D1); end
      default: begin cmd_a = AW'(SEQ_A2); cmd_d = DW'(SEQ_D2); end
    endcase
  end

  assign fl_addr = (host_busy && step_q != LAST_STEP) ? cmd_a : tgt_a_q;
  assign fl_dq_o = (step_q != LAST_STEP) ? cmd_d : tgt_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      ph_q     <= '0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_dq_oe <= 1'b0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      ph_q     <= ph_d;
      fl_ce_n  <= !ce_d;
      fl_oe_n  <= !oe_d;
      fl_we_n  <= !we_d;
      fl_dq_oe <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_a_q <= '0;
      tgt_d_q <= '0;
    end else if (host_ack) begin
      tgt_a_q <= host_addr;
      tgt_d_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_err <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_rd;
      if (cap_rd) rd_data <= fl_dq_i;
      if (host_ack)              host_err <= 1'b0;
      else if (waiting && fin_tmo) host_err <= 1'b1;
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_dq_oe && !fl_oe_n)); // R11
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n)); // R11
  AST_WE_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o))); // R5
  AST_WE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o) && fl_dq_oe)); // R5
  AST_ACK_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> !host_busy); // R8
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_err) |-> $fell(host_busy)); // R9
  AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!fl_oe_n)); // R3

endmodule

// File: tb/sim_nor_pgm_seq.sv
module sim_nor_pgm_seq;

  localparam int AW = 20, DW = 16, WE = 3, RDC = 2, TMO = 40, SYN = 2;
  localparam int WR_SPAN = 4 * (WE + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ack, host_busy, host_err, rd_valid;
  logic [DW-1:0] rd_data;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;
  logic fl_rdy_m = 1'b1;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  nor_pgm_seq #(.AW(AW), .DW(DW), .WE_LOW_CLKS(WE), .RD_CLKS(RDC),
                .TMO_LIMIT(TMO), .SYNC_STAGES(SYN)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_busy(host_busy), .host_err(host_err), .rd_valid(rd_valid),
    .rd_data(rd_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .fl_rdy(fl_rdy_m)
  );

  // ---------------- flash model and bus monitor ----------------
  logic [15:0] mem [256];
  logic [19:0] log_a [8];
  logic [15:0] log_d [8];
  int          log_lo [8];
  int log_n = 0, seq_pos = 0, busy_left = 0, busy_clks = 4;
  int mon_contend = 0, mon_oe_in_wr = 0, mon_stab_bad = 0, lo_cnt = 0;
  logic p_we = 1'b1;
  logic [19:0] p_a = '0;
  logic [15:0] p_d = '0;

  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr[7:0]] : 16'h0BAD;

  function automatic logic [15:0] init_word(input logic [7:0] a);
    return 16'({8'h00, a} * 257) ^ 16'h5A00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_left > 0) begin
        busy_left = busy_left - 1;
        if (busy_left == 0) fl_rdy_m = 1'b1;
      end
      if (fl_dq_oe && !fl_oe_n) mon_contend++;
      if (!fl_we_n && (!fl_oe_n || fl_ce_n)) mon_oe_in_wr++;
      if (p_we && !fl_we_n) begin
        if (fl_addr != p_a || fl_dq_o != p_d) mon_stab_bad++;
        lo_cnt = 1;
      end else if (!p_we && !fl_we_n) begin
        if (fl_addr != p_a || fl_dq_o != p_d) mon_stab_bad++;
        lo_cnt++;
      end else if (!p_we && fl_we_n) begin
        if (fl_addr != p_a || fl_dq_o != p_d || !fl_dq_oe) mon_stab_bad++;
        if (log_n < 8) begin
          log_a[log_n] = p_a; log_d[log_n] = p_d; log_lo[log_n] = lo_cnt;
        end
        log_n++;
        if (seq_pos == 0 && p_a == 20'h555 && p_d == 16'hAA) seq_pos = 1;
        else if (seq_pos == 1 && p_a == 20'h2AA && p_d == 16'h55) seq_pos = 2;
        else if (seq_pos == 2 && p_a == 20'h555 && p_d == 16'hA0) seq_pos = 3;
        else if (seq_pos == 3) begin
          mem[p_a[7:0]] = p_d;
          fl_rdy_m  = 1'b0;
          busy_left = busy_clks;
          seq_pos   = 0;
        end else seq_pos = 0;
      end
      p_we = fl_we_n; p_a = fl_addr; p_d = fl_dq_o;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [19:0] a, input logic [15:0] d);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    #1;
    for (int i = 0; i < 400 && !host_ack; i++) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a, input logic [15:0] exp, input string tag);
    int strobes = 0;
    issue(1'b0, a, 16'h0);
    for (int i = 0; i < 20 && !rd_valid; i++) begin
      if (!fl_ce_n && !fl_oe_n && fl_we_n && fl_addr == a) strobes++;
      @(negedge clk);
    end
    chk("R2", {tag, " read strobe clocks"}, strobes, RDC);
    chk("R3", {tag, " rd_valid"}, rd_valid, 1'b1);
    chk("R3", {tag, " rd_data"}, rd_data, exp);
    @(negedge clk);
    chk("R3", {tag, " rd_valid single pulse"}, rd_valid, 1'b0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1", "ce_n in reset", fl_ce_n, 1'b1);
    chk("R1", "oe_n in reset", fl_oe_n, 1'b1);
    chk("R1", "we_n in reset", fl_we_n, 1'b1);
    chk("R1", "dq_oe in reset", fl_dq_oe, 1'b0);
    chk("R1", "busy/err/valid in reset", {host_busy, host_err, rd_valid}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, host_busy}, 5'b11100);
  endtask

  task automatic t_read;
    do_read(20'h00011, init_word(8'h11), "plain A");
    do_read(20'hABCF0, init_word(8'hF0), "plain B");
  endtask

  task automatic t_program(input logic [19:0] a, input logic [15:0] d, input int b, input string tag);
    int bcyc = 0;
    busy_clks = b; log_n = 0;
    issue(1'b1, a, d);
    chk("R6", {tag, " busy after ack"}, host_busy, 1'b1);
    for (int i = 0; i < 500 && host_busy; i++) begin
      bcyc++;
      @(negedge clk);
    end
    // ready rises at the b-th falling edge after WE; two sync flops, then one clock to idle
    chk("R6", {tag, " busy length"}, bcyc, WR_SPAN + 2 + b);
    chk("R9", {tag, " no error"}, host_err, 1'b0);
    chk("R4", {tag, " write count"}, log_n, 4);
    chk("R4", {tag, " unlock 1"}, {log_a[0], log_d[0]}, {20'h555, 16'hAA});
    chk("R4", {tag, " unlock 2"}, {log_a[1], log_d[1]}, {20'h2AA, 16'h55});
    chk("R4", {tag, " setup"}, {log_a[2], log_d[2]}, {20'h555, 16'hA0});
    chk("R4", {tag, " data cycle"}, {log_a[3], log_d[3]}, {a, d});
    for (int k = 0; k < 4; k++) chk("R5", {tag, " WE low clocks"}, log_lo[k], WE);
    chk("R5", {tag, " setup/hold stability"}, mon_stab_bad, 0);
    do_read(a, d, {tag, " readback"});
    chk("R7", {tag, " no extra writes"}, log_n, 4);
  endtask

  task automatic t_held_read;
    int ack_busy = 0;
    busy_clks = 15; log_n = 0;
    issue(1'b1, 20'h0033C, 16'h1234);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 20'h0033C;
    #1;
    for (int i = 0; i < 300 && !host_ack; i++) begin
      if (host_ack && host_busy) ack_busy++;
      @(negedge clk); #1;
    end
    chk("R8", "ack while busy", ack_busy, 0);
    chk("R8", "busy at ack", host_busy, 1'b0);
    @(negedge clk); host_req = 1'b0;
    for (int i = 0; i < 20 && !rd_valid; i++) @(negedge clk);
    chk("R7", "held read returns programmed word", rd_data, 16'h1234);
    chk("R7", "held read writes", log_n, 4);
  endtask

  task automatic t_timeout;
    int bcyc = 0;
    busy_clks = 100; log_n = 0;
    issue(1'b1, 20'h00077, 16'h0F0F);
    for (int i = 0; i < 500 && host_busy; i++) begin
      bcyc++;
      @(negedge clk);
    end
    chk("R9", "busy length on timeout", bcyc, WR_SPAN + TMO);
    chk("R9", "err raised", host_err, 1'b1);
    for (int i = 0; i < 200 && !fl_rdy_m; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9", "err persists", host_err, 1'b1);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 20'h00022;
    #1;
    for (int i = 0; i < 20 && !host_ack; i++) begin @(negedge clk); #1; end
    @(negedge clk); host_req = 1'b0;
    chk("R10", "err cleared on next ack", host_err, 1'b0);
    for (int i = 0; i < 20 && !rd_valid; i++) @(negedge clk);
    chk("R10", "read after timeout data", rd_data, init_word(8'h22));
  endtask

  // ---------------- main ----------------
  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_word(8'(i));
    repeat (2) @(negedge clk);
    t_reset();
    t_read();
    t_program(20'h12345, 16'hBEEF, 6, "prog A");
    t_program(20'hFFF80, 16'h0000, 2, "prog B");
    t_held_read();
    t_timeout();
    repeat (3) @(negedge clk);
    chk("R11", "bus driven with OE low", mon_contend, 0);
    chk("R11", "WE low with OE low or CE high", mon_oe_in_wr, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL ALL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

endmodule